// File: doc/BRIEF.md
# Frequency-Change Watchdog with Recovery Reset

This block protects a system while its clock frequency is being reprogrammed. Software sets the enable bit, then changes the frequency. The change pulse arms a down-counter, which is clocked by a slow unit tick. If software does not disable the timer before the count runs out, the block does three things: it raises a sticky time-out status bit, it can pull the system reset line low for a fixed number of clock cycles, and it enters a locked recovery mode. In that mode further frequency changes are refused and the recovery frequency is applied. The lock is released only by clearing the enable bit.

The time unit comes from a base tick input, which a parameterised prescaler divides. The short scale divides by `SHORT_DIV` and the long scale by `LONG_DIV`. With a 50 ms base tick these give 150 ms and 2.5 s. A 5-bit time-out field value v gives a time-out of v+1 units, so the range is 150 ms to 4.8 s on the short scale and 2.5 s to 80 s on the long scale. A second enable bit makes every accepted frequency change produce a reset pulse as well.

Top module: `wdt_recover`

## Requirements
- R1: After reset, `status_timeout`, `recovery_lock` and `rst_pull_low` are all 0.
- R2: With `cfg_enable` at 1, the timer does not count until a `freq_change` pulse is seen. Without such a pulse, no time-out occurs however many base ticks arrive.
- R3: After an arming `freq_change`, a time-out occurs on exactly the (v+1)·D-th base tick, where v is `cfg_timeout` and D is `SHORT_DIV` when `cfg_long_scale` is 0 and `LONG_DIV` when it is 1.
- R4: A `freq_change` that arrives while the timer is counting restarts the count from the full value, and the prescaler restarts as well.
- R5: Driving `cfg_enable` to 0 stops the count and reloads it. Setting `cfg_enable` back to 1 does not resume the count until a new `freq_change` arrives.
- R6: `status_timeout` goes to 1 on the cycle a time-out occurs and then holds, whatever `cfg_enable` does. A one-cycle `status_clr` pulse (a write of 1) clears it. With `status_clr` at 0 (a write of 0), it is left unchanged.
- R7: A time-out with `cfg_rst_on_timeout` at 1 drives `rst_pull_low` to 1 for exactly `RST_CYCLES` clock cycles, starting on the time-out cycle. With `cfg_rst_on_timeout` at 0, a time-out leaves `rst_pull_low` at 0.
- R8: When `cfg_rst_on_freq` is 1, every accepted `freq_change` drives `rst_pull_low` to 1 for exactly `RST_CYCLES` cycles, whatever the value of `cfg_enable`. With `cfg_rst_on_freq` at 0, a `freq_change` produces no pulse.
- R9: A time-out sets `recovery_lock`. The lock stays at 1 while `cfg_enable` stays at 1, and `status_clr` does not affect it. Driving `cfg_enable` to 0 clears it on the next cycle.
- R10: While `recovery_lock` is 1, `freq_change` is ignored: it neither arms the timer nor produces a reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_timeout | input | TO_W | Time-out field; v gives v+1 units |
| cfg_long_scale | input | 1 | Unit select: 0 short, 1 long |
| cfg_enable | input | 1 | Watchdog enable; 0 stops, reloads and unlocks |
| cfg_rst_on_timeout | input | 1 | Reset pulse on time-out |
| cfg_rst_on_freq | input | 1 | Reset pulse on accepted frequency change |
| freq_change | input | 1 | One-cycle frequency-change event |
| base_tick | input | 1 | One-cycle slow base tick |
| status_clr | input | 1 | One-cycle write-one-to-clear of the status bit |
| status_timeout | output | 1 | Sticky time-out status |
| recovery_lock | output | 1 | Locked recovery mode is active |
| rst_pull_low | output | 1 | 1 = pull the open-drain reset line low; 0 = release |

## Verification
A table of vectors covers the main count. It pairs time-out values 0, small, mid and 31 with both unit scales, so that a wrong prescaler divisor, an off-by-one in the v+1 rule and a truncated count field each show as a time-out that comes one tick early or late. Each vector checks the status one tick before the expected expiry and again on it.

Directed sequences then cover four further cases:
- enabling the timer without a change event, and disabling it mid-count, to separate arming from enabling;
- restarting the count with a second change event;
- write-one-to-clear against sticky hold;
- change events refused under lock, so that reset pulses caused by a frequency change can be told apart from pulses caused by a time-out.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    WDT_SCALE_SHORT = 1'b0,
    WDT_SCALE_LONG  = 1'b1
  } wdt_scale_e;

  // Last prescaler count value before a unit tick for the chosen scale.
  function automatic int unsigned wdt_div_last(input logic long_sel,
                                               input int unsigned short_div,
                                               input int unsigned long_div);
    return (long_sel == WDT_SCALE_LONG) ? long_div - 1 : short_div - 1;
  endfunction

  // Number of base ticks from arming to expiry for a field value.
  function automatic int unsigned wdt_ticks_to_expiry(input int unsigned field,
                                                      input int unsigned div);
    return (field + 1) * div;
  endfunction

endpackage

// File: rtl/wdt_unit_gen.sv
module wdt_unit_gen
  import wdt_pkg::*;
#(
  parameter int unsigned SHORT_DIV = 3,
  parameter int unsigned LONG_DIV  = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic long_sel,
  input  logic base_tick,
  output logic unit_tick
);
  localparam int unsigned MAX_DIV = (SHORT_DIV > LONG_DIV) ? SHORT_DIV : LONG_DIV;
  localparam int unsigned PW      = $clog2(MAX_DIV + 1);

  logic [PW-1:0] pre_cnt;
  logic [PW-1:0] pre_last;
  logic          at_last;

  assign pre_last  = PW'(wdt_div_last(long_sel, SHORT_DIV, LONG_DIV));
  assign at_last   = (pre_cnt >= pre_last);
  assign unit_tick = run & base_tick & ~clear & at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
    end else if (clear) begin
      pre_cnt <= '0;
    end else if (run && base_tick) begin
      pre_cnt <= at_last ? '0 : pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned TO_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            freq_change,
  input  logic [TO_W-1:0] reload,
  input  logic            unit_tick,
  input  logic            status_clr,
  output logic            arm_evt,
  output logic            timeout_evt,
  output logic            running,
  output logic            status,
  output logic            lock
);
  logic [TO_W-1:0] cnt;

  assign arm_evt     = enable & freq_change & ~lock;
  assign timeout_evt = running & unit_tick & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      lock    <= 1'b0;
    end else if (!enable) begin
      running <= 1'b0;
      cnt     <= reload;
      lock    <= 1'b0;
    end else if (arm_evt) begin
      running <= 1'b1;
      cnt     <= reload;
    end else if (timeout_evt) begin
      running <= 1'b0;
      cnt     <= reload;
      lock    <= 1'b1;
    end else if (running && unit_tick) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= 1'b0;
    end else if (timeout_evt) begin
      status <= 1'b1;
    end else if (status_clr) begin
      status <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int unsigned RST_CYCLES = 150000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic pull_low
);
  localparam int unsigned RW = $clog2(RST_CYCLES + 1);

  logic [RW-1:0] left;

  assign pull_low = (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
    end else if (trigger) begin
      left <= RW'(RST_CYCLES);
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_recover.sv
module wdt_recover #(
  parameter int unsigned TO_W       = 5,
  parameter int unsigned SHORT_DIV  = 3,
  parameter int unsigned LONG_DIV   = 50,
  parameter int unsigned RST_CYCLES = 150000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TO_W-1:0] cfg_timeout,
  input  logic            cfg_long_scale,
  input  logic            cfg_enable,
  input  logic            cfg_rst_on_timeout,
  input  logic            cfg_rst_on_freq,
  input  logic            freq_change,
  input  logic            base_tick,
  input  logic            status_clr,
  output logic            status_timeout,
  output logic            recovery_lock,
  output logic            rst_pull_low
);
  logic arm_evt;
  logic timeout_evt;
  logic running;
  logic unit_tick;
  logic pre_clear;
  logic freq_ok;
  logic pulse_trig;

  assign pre_clear  = arm_evt | ~cfg_enable;
  assign freq_ok    = freq_change & ~recovery_lock;
  assign pulse_trig = (timeout_evt & cfg_rst_on_timeout) | (freq_ok & cfg_rst_on_freq);

  wdt_unit_gen #(
    .SHORT_DIV (SHORT_DIV),
    .LONG_DIV  (LONG_DIV)
  ) u_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (pre_clear),
    .run       (running),
    .long_sel  (cfg_long_scale),
    .base_tick (base_tick),
    .unit_tick (unit_tick)
  );

  wdt_countdown #(
    .TO_W (TO_W)
  ) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (cfg_enable),
    .freq_change (freq_change),
    .reload      (cfg_timeout),
    .unit_tick   (unit_tick),
    .status_clr  (status_clr),
    .arm_evt     (arm_evt),
    .timeout_evt (timeout_evt),
    .running     (running),
    .status      (status_timeout),
    .lock        (recovery_lock)
  );

  wdt_rst_pulse #(
    .RST_CYCLES (RST_CYCLES)
  ) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .trigger  (pulse_trig),
    .pull_low (rst_pull_low)
  );
endmodule

// File: rtl/wdt_recover_chk.sv
module wdt_recover_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_enable,
  input logic cfg_rst_on_timeout,
  input logic status_clr,
  input logic status_timeout,
  input logic recovery_lock,
  input logic rst_pull_low,
  input logic timeout_evt,
  input logic running,
  input logic unit_tick
);
  // R3: unit ticks only advance an armed timer
  p_unit_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    unit_tick |-> running);

  // R5: disabling stops the count
  p_disable_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !running);

  // R6: time-out sets the sticky status
  p_timeout_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> status_timeout);

  // R6: status holds without a clear strobe
  p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_timeout && !status_clr) |=> status_timeout);

  // R6: clear strobe empties the status
  p_status_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && !timeout_evt) |=> !status_timeout);

  // R7: enabled time-out pulls reset low
  p_timeout_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_evt && cfg_rst_on_timeout) |=> rst_pull_low);

  // R9: time-out enters the lock
  p_timeout_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> recovery_lock);

  // R9: lock holds while enabled
  p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (recovery_lock && cfg_enable) |=> recovery_lock);

  // R9: disabling releases the lock
  p_lock_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !recovery_lock);

  // R10: a locked block never counts
  p_locked_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_lock |-> !running);
endmodule

bind wdt_recover wdt_recover_chk u_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .cfg_enable         (cfg_enable),
  .cfg_rst_on_timeout (cfg_rst_on_timeout),
  .status_clr         (status_clr),
  .status_timeout     (status_timeout),
  .recovery_lock      (recovery_lock),
  .rst_pull_low       (rst_pull_low),
  .timeout_evt        (timeout_evt),
  .running            (running),
  .unit_tick          (unit_tick)
);

// File: tb/sim_wdt_recover.sv
module sim_wdt_recover;
  localparam int SHORT_D = 3;
  localparam int LONG_D  = 5;
  localparam int PULSE   = 8;
  localparam int NVEC    = 6;
  // vector: {rst_on_timeout, long_scale, field[4:0]}
  localparam logic [6:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 5'd0},
    {1'b0, 1'b0, 5'd31},
    {1'b0, 1'b1, 5'd0},
    {1'b1, 1'b1, 5'd31},
    {1'b1, 1'b1, 5'd5},
    {1'b1, 1'b0, 5'd12}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] cfg_timeout = 5'd0;
  logic       cfg_long_scale = 1'b0;
  logic       cfg_enable = 1'b0;
  logic       cfg_rst_on_timeout = 1'b0;
  logic       cfg_rst_on_freq = 1'b0;
  logic       freq_change = 1'b0;
  logic       base_tick = 1'b0;
  logic       status_clr = 1'b0;
  logic       status_timeout;
  logic       recovery_lock;
  logic       rst_pull_low;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  wdt_recover #(
    .TO_W(5), .SHORT_DIV(SHORT_D), .LONG_DIV(LONG_D), .RST_CYCLES(PULSE)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout),
    .cfg_long_scale(cfg_long_scale), .cfg_enable(cfg_enable),
    .cfg_rst_on_timeout(cfg_rst_on_timeout), .cfg_rst_on_freq(cfg_rst_on_freq),
    .freq_change(freq_change), .base_tick(base_tick), .status_clr(status_clr),
    .status_timeout(status_timeout), .recovery_lock(recovery_lock),
    .rst_pull_low(rst_pull_low)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) base_tick = 1'b1;
      @(negedge clk) base_tick = 1'b0;
    end
  endtask

  task automatic pulse_freq();
    @(negedge clk) freq_change = 1'b1;
    @(negedge clk) freq_change = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) status_clr = 1'b1;
    @(negedge clk) status_clr = 1'b0;
  endtask

  task automatic pulse_width(output int w);
    w = 0;
    while (rst_pull_low && w < 100) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic fresh(input logic [4:0] v, input logic lng, input logic rto);
    @(negedge clk) cfg_enable = 1'b0;
    idle(1);
    pulse_clr();
    cfg_timeout = v; cfg_long_scale = lng; cfg_rst_on_timeout = rto;
    cfg_rst_on_freq = 1'b0;
    cfg_enable = 1'b1;
    idle(1);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int w;
    int n;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check(status_timeout == 0, "R1 status", status_timeout, 0);
    check(recovery_lock == 0, "R1 lock", recovery_lock, 0);
    check(rst_pull_low == 0, "R1 pull", rst_pull_low, 0);

    // Vector table: R3 expiry tick, R7 pulse, R9 lock
    for (int k = 0; k < NVEC; k++) begin
      fresh(VEC[k][4:0], VEC[k][5], VEC[k][6]);
      n = (int'(VEC[k][4:0]) + 1) * (VEC[k][5] ? LONG_D : SHORT_D);
      pulse_freq();
      ticks(n - 1);
      check(status_timeout == 0, "R3 early", status_timeout, 0);
      ticks(1);
      check(status_timeout == 1, "R3 expiry", status_timeout, 1);
      check(recovery_lock == 1, "R9 lock set", recovery_lock, 1);
      check(rst_pull_low == VEC[k][6], "R7 pulse start", rst_pull_low, VEC[k][6]);
      pulse_width(w);
      check(w == (VEC[k][6] ? PULSE : 0), "R7 pulse width", w, VEC[k][6] ? PULSE : 0);
    end

    // R2: enable alone does not start the count
    fresh(5'd0, 1'b0, 1'b0);
    ticks(20);
    check(status_timeout == 0, "R2 no arm", status_timeout, 0);

    // R4: restart while counting (v=2 short -> 9 ticks)
    fresh(5'd2, 1'b0, 1'b0);
    pulse_freq();
    ticks(8);
    pulse_freq();
    ticks(8);
    check(status_timeout == 0, "R4 restarted", status_timeout, 0);
    ticks(1);
    check(status_timeout == 1, "R4 expiry", status_timeout, 1);

    // R6: sticky without clear, survives disable, cleared by strobe
    idle(5);
    check(status_timeout == 1, "R6 hold", status_timeout, 1);
    // R9: clear strobe does not release the lock
    pulse_clr();
    check(status_timeout == 0, "R6 clear", status_timeout, 0);
    check(recovery_lock == 1, "R9 lock kept", recovery_lock, 1);

    // R10: change event under lock ignored, no pulse, no arm
    cfg_rst_on_freq = 1'b1;
    pulse_freq();
    check(rst_pull_low == 0, "R10 no pulse", rst_pull_low, 0);
    ticks(12);
    check(status_timeout == 0, "R10 no arm", status_timeout, 0);
    @(negedge clk) cfg_enable = 1'b0;
    idle(1);
    check(recovery_lock == 0, "R9 release", recovery_lock, 0);

    // R8: frequency-change pulse with enable at 0
    pulse_freq();
    check(rst_pull_low == 1, "R8 pulse start", rst_pull_low, 1);
    pulse_width(w);
    check(w == PULSE, "R8 pulse width", w, PULSE);
    cfg_rst_on_freq = 1'b0;
    pulse_freq();
    check(rst_pull_low == 0, "R8 disabled", rst_pull_low, 0);

    // R6: enable state does not touch status; time out then disable
    fresh(5'd0, 1'b0, 1'b0);
    pulse_freq();
    ticks(3);
    @(negedge clk) cfg_enable = 1'b0;
    idle(2);
    check(status_timeout == 1, "R6 survives disable", status_timeout, 1);

    // R5: disable mid-count stops, re-enable needs a new event
    fresh(5'd1, 1'b0, 1'b0);
    pulse_freq();
    ticks(4);
    @(negedge clk) cfg_enable = 1'b0;
    ticks(4);
    @(negedge clk) cfg_enable = 1'b1;
    ticks(10);
    check(status_timeout == 0, "R5 stopped", status_timeout, 0);
    pulse_freq();
    ticks(5);
    check(status_timeout == 0, "R5 reloaded", status_timeout, 0);
    ticks(1);
    check(status_timeout == 1, "R5 full count", status_timeout, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule